// File: doc/BRIEF.md
# Fixed-Frequency Chopper Current Regulator

This block regulates the peak current in two motor windings by chopping each winding's bridge on and off at a fixed rate. One period counter is shared by both channels. Each time it wraps, it turns on the bridge of every enabled channel in the same clock cycle. A channel then stays on until its over-current input reports that the sense voltage has crossed the reference. That input is a single bit coming from an external comparator. The over-current bit turns off that channel only, and the channel stays off until the next period start.

Every turn-on opens a blanking window. During this window the over-current bit is ignored, so the switching spike at turn-on cannot end the on-time early. As a result, the shortest possible on-time is the blanking length. For each channel, the block counts the on-cycles in every period and raises a flag when the count exceeds half the period, which is the region where chopping becomes unstable.

Each channel runs a three-state machine with these states:
- `CH_OFF`: the bridge is off.
- `CH_BLANK`: the bridge is on and the comparator is masked.
- `CH_SENSE`: the bridge is on and the comparator is watched.

The transitions are:
- `turn_on` (CH_OFF→CH_BLANK): on a period start while enabled.
- `blank_done` (CH_BLANK→CH_SENSE): at the end of the window with the over-current bit low.
- `blank_trip` (CH_BLANK→CH_OFF): at the end of the window with the over-current bit still high.
- `trip` (CH_SENSE→CH_OFF): on the over-current bit.
- `kill` (CH_BLANK or CH_SENSE→CH_OFF): when the enable goes low.

Top module: `chop_regulator`

## Requirements
- R1: Both channels share one period of `PERIOD_CYC` clocks. The first period starts in the cycle in which reset is released, and each later period starts `PERIOD_CYC` cycles after the one before. At each period start, every enabled channel that is off turns on, and its `chop_o` bit rises in the following cycle.
- R2: An over-current on one channel turns off only that channel. The on-time of the other channel is not affected.
- R3: For the first `BLANK_CYC` cycles after a turn-on, `chop_o` stays high whatever the over-current bit does.
- R4: If the synchronized over-current bit is still high when blanking ends, the channel turns off right away. This gives an on-time of exactly `BLANK_CYC` cycles, which is the minimum on-time.
- R5: After blanking, an over-current bit raised in cycle c drives `chop_o` low from cycle c+3. The input passes through two synchronizer flops, and the state change adds one more cycle.
- R6: `duty_flag_o[i]` is updated once per period, in the cycle in which the next period starts. It is 1 when channel i was on for more than `PERIOD_CYC/2` of the `PERIOD_CYC` cycles of the period just ended, and it holds that value until the next update.
- R7: When `en_i[i]` is low at a clock edge, `chop_o[i]` is low after that edge, and the channel does not turn on at any period start while the enable stays low.
- R8: A channel that has not tripped stays on across a period start. No new blanking window starts, so an over-current after that start turns the channel off with the R5 timing.
- R9: Reset is synchronous and active high. While it is applied, `chop_o` and `duty_flag_o` are all zero and the period counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oc_raw_i | input | NUM_CH | Over-current comparator bits, asynchronous, one per channel |
| en_i | input | NUM_CH | Channel enable; low forces the bridge off |
| chop_o | output | NUM_CH | Bridge-on command, one per channel |
| duty_flag_o | output | NUM_CH | High when the previous period's on-time exceeded half the period |

## Verification
The properties assume that the over-current bits may change at any time but are seen only after the synchronizer, and that enables change only between clock edges. They also assume that `BLANK_CYC` is smaller than `PERIOD_CYC`, which is checked during elaboration. The stimulus releases each over-current bit only after the channel has turned off and before the next period's blanking ends. It changes enables only at negative clock edges, a fixed number of cycles after a channel's turn-on, so that every expected on-time can be derived from the trip cycle alone.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_BLANK = 2'd1,
        CH_SENSE = 2'd2
    } ch_state_t;
endpackage

// File: rtl/chop_timebase.sv
module chop_timebase #(
    parameter int PERIOD_CYC = 4348
) (
    input  logic clk,
    input  logic rst,
    output logic start_o,
    output logic end_o
);
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign start_o = (cnt_q == '0);
    assign end_o   = (cnt_q == LAST);

    // R1: one start pulse per period, never two in a row
    a_r1_single_start: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);
    // R1: the last cycle of a period is followed by a start
    a_r1_end_then_start: assert property (@(posedge clk) disable iff (rst)
        end_o |=> start_o);
endmodule

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/chop_channel.sv
module chop_channel
    import chop_pkg::*;
#(
    parameter int PERIOD_CYC = 4348,
    parameter int BLANK_CYC  = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic end_i,
    input  logic en_i,
    input  logic oc_i,
    output logic chop_o,
    output logic duty_flag_o
);
    localparam int BW   = $clog2(BLANK_CYC + 1);
    localparam int OW   = $clog2(PERIOD_CYC + 1);
    localparam int HALF = PERIOD_CYC / 2;
    localparam logic [BW-1:0] BLAST = BW'(BLANK_CYC - 1);

    ch_state_t     state_q, state_d;
    logic [BW-1:0] bcnt_q;
    logic [OW-1:0] on_cnt_q;
    logic [OW-1:0] on_total;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_OFF;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (en_i && start_i) state_d = CH_BLANK;          // turn_on
            end
            CH_BLANK: begin
                if (!en_i)                state_d = CH_OFF;        // kill
                else if (bcnt_q == BLAST) state_d = oc_i ? CH_OFF  // blank_trip
                                                         : CH_SENSE; // blank_done
            end
            CH_SENSE: begin
                if (!en_i || oc_i) state_d = CH_OFF;               // kill / trip
            end
            default: state_d = CH_OFF;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_BLANK, CH_SENSE: chop_o = 1'b1;
            default:            chop_o = 1'b0;
        endcase
    end

    // blanking window counter
    always_ff @(posedge clk) begin
        if (rst || state_q != CH_BLANK) bcnt_q <= '0;
        else                            bcnt_q <= bcnt_q + 1'b1;
    end

    // per-period on-time measure and duty flag
    assign on_total = on_cnt_q + OW'(chop_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            on_cnt_q    <= '0;
            duty_flag_o <= 1'b0;
        end else if (end_i) begin
            on_cnt_q    <= '0;
            duty_flag_o <= (on_total > OW'(HALF));
        end else begin
            on_cnt_q    <= on_total;
        end
    end

    // checker state: length of the current on run
    logic [OW-1:0] run_q;
    logic          rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                              run_q <= '0;
        else if (!chop_o)                     run_q <= '0;
        else if (run_q != OW'(PERIOD_CYC))    run_q <= run_q + 1'b1;
    end

    a_r1_set_on_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && en_i && !chop_o) |=> chop_o);
    a_r3_blank_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_BLANK && en_i && bcnt_q != BLAST) |=> chop_o);
    a_r4_min_on: assert property (@(posedge clk) disable iff (rst)
        ($fell(chop_o) && $past(en_i)) |-> (run_q >= OW'(BLANK_CYC)));
    a_r5_trip_off: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_SENSE && oc_i) |=> !chop_o);
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !end_i |=> $stable(duty_flag_o));
    a_r7_disable_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !chop_o);
    a_r8_no_reblank: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_SENSE && !oc_i && en_i) |=> (state_q == CH_SENSE));

    always @(posedge clk) begin
        if (rst_q) begin
            a_r9_reset_off: assert (!chop_o && !duty_flag_o);
        end
    end
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator #(
    parameter int NUM_CH     = 2,
    parameter int PERIOD_CYC = 4348,
    parameter int BLANK_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] oc_raw_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic [NUM_CH-1:0] chop_o,
    output logic [NUM_CH-1:0] duty_flag_o
);
    if (BLANK_CYC < 1 || BLANK_CYC >= PERIOD_CYC) begin : g_bad_cfg
        $error("chop_regulator: BLANK_CYC must be in 1..PERIOD_CYC-1");
    end

    logic              start_w;
    logic              end_w;
    logic [NUM_CH-1:0] oc_s;

    chop_timebase #(.PERIOD_CYC(PERIOD_CYC)) u_timebase (
        .clk     (clk),
        .rst     (rst),
        .start_o (start_w),
        .end_o   (end_w)
    );

    chop_sync #(.W(NUM_CH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (oc_raw_i),
        .q_o (oc_s)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chop_channel #(
            .PERIOD_CYC (PERIOD_CYC),
            .BLANK_CYC  (BLANK_CYC)
        ) u_ch (
            .clk         (clk),
            .rst         (rst),
            .start_i     (start_w),
            .end_i       (end_w),
            .en_i        (en_i[i]),
            .oc_i        (oc_s[i]),
            .chop_o      (chop_o[i]),
            .duty_flag_o (duty_flag_o[i])
        );
    end
endmodule

// File: tb/chop_regulator_bench.sv
module chop_regulator_bench;
    localparam int P = 40;
    localparam int B = 5;
    localparam int NV = 6;

    // entry: {d0, d1, en1, t0, t1}; dN = trip offset after turn-on, tN = expected on-cycles
    localparam logic [39:0] VEC [NV] = '{
        {8'd0,  8'd0,  8'd1, 8'd5,  8'd5 },
        {8'd2,  8'd3,  8'd1, 8'd5,  8'd6 },
        {8'd10, 8'd17, 8'd1, 8'd13, 8'd20},
        {8'd18, 8'd28, 8'd1, 8'd21, 8'd31},
        {8'd3,  8'd28, 8'd0, 8'd6,  8'd0 },
        {8'd25, 8'd1,  8'd1, 8'd28, 8'd5 }
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] oc;
    logic [1:0] en;
    logic [1:0] chop;
    logic [1:0] duty;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    chop_regulator #(.NUM_CH(2), .PERIOD_CYC(P), .BLANK_CYC(B)) u_chop_regulator (
        .clk         (clk),
        .rst         (rst),
        .oc_raw_i    (oc),
        .en_i        (en),
        .chop_o      (chop),
        .duty_flag_o (duty)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise0();
        logic p;
        p = chop[0];
        for (int n = 0; n < 3 * P; n++) begin
            @(negedge clk);
            if (chop[0] && !p) return;
            p = chop[0];
        end
        check("R1 turn-on seen", 0, 1);
    endtask

    initial begin
        int f0, f1;
        int d0, d1, t0, t1, c0, c1;
        logic e1;
        rst = 1'b1;
        oc  = 2'b00;
        en  = 2'b11;
        repeat (3) @(negedge clk);
        check("R9 chop in reset", int'(chop), 0);
        check("R9 flag in reset", int'(duty), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 R1 turn-on right after reset", int'(chop), 3);

        f0 = -1; f1 = -1;
        for (int v = 0; v < NV; v++) begin
            d0 = int'(VEC[v][39:32]); d1 = int'(VEC[v][31:24]);
            e1 = VEC[v][16];
            t0 = int'(VEC[v][15:8]);  t1 = int'(VEC[v][7:0]);
            if (f0 >= 0) begin
                check("R6 flag ch0", int'(duty[0]), f0);
                check("R6 flag ch1", int'(duty[1]), f1);
            end
            check("R1 shared start ch1", int'(chop[1]), int'(e1));
            c0 = 0; c1 = 0;
            for (int j = 0; j <= P - 3; j++) begin
                c0 += int'(chop[0]);
                c1 += int'(chop[1]);
                if (j == d0) oc[0] = 1'b1;
                if (j == d1) oc[1] = 1'b1;
                if (j == d0 + B + 4) oc[0] = 1'b0;
                if (j == d1 + B + 4) oc[1] = 1'b0;
                @(negedge clk);
            end
            oc = 2'b00;
            check("R2 R3 R4 R5 on-time ch0", c0, t0);
            check("R2 R3 R4 R5 on-time ch1", c1, t1);
            f0 = (t0 > P / 2) ? 1 : 0;
            f1 = (t1 > P / 2) ? 1 : 0;
            en[1] = (v + 1 < NV) ? VEC[v + 1][16] : 1'b1;
            wait_rise0();
        end

        // directed: ch1 never trips, stays on across the start (R8, R6)
        check("R6 flag ch0 last vector", int'(duty[0]), f0);
        check("R6 flag ch1 last vector", int'(duty[1]), f1);
        c1 = 0;
        for (int j = 0; j <= P - 3; j++) begin
            c1 += int'(chop[1]);
            if (j == 5) oc[0] = 1'b1;
            if (j == 5 + B + 4) oc[0] = 1'b0;
            @(negedge clk);
        end
        check("R8 ch1 on all period", c1, P - 2);
        check("R8 ch1 on before start", int'(chop[1]), 1);
        @(negedge clk);
        check("R8 ch1 on at start", int'(chop[1]), 1);
        @(negedge clk);
        check("R1 ch0 turn-on", int'(chop[0]), 1);
        check("R6 flag ch1 long on", int'(duty[1]), 1);
        check("R6 flag ch0 short on", int'(duty[0]), 0);
        // ch1 is in sensing already: trip obeys R5 timing, no new blanking
        for (int j = 0; j <= 4; j++) begin
            if (j == 0) oc[1] = 1'b1;
            if (j == 2) check("R8 ch1 still on j2", int'(chop[1]), 1);
            if (j == 3) check("R8 R5 ch1 off without reblank", int'(chop[1]), 0);
            @(negedge clk);
        end
        oc[1] = 1'b0;

        // directed: enable low forces off and blocks turn-on (R7); ch0 never tripped
        check("R7 ch0 on before disable", int'(chop[0]), 1);
        en[0] = 1'b0;
        @(negedge clk);
        check("R7 ch0 off after disable", int'(chop[0]), 0);
        c0 = 0;
        for (int j = 0; j < P + 2; j++) begin
            c0 += int'(chop[0]);
            @(negedge clk);
        end
        check("R7 no turn-on while disabled", c0, 0);
        en[0] = 1'b1;

        // directed: reset mid-run (R9)
        wait_rise0();
        rst = 1'b1;
        @(negedge clk);
        check("R9 chop cleared", int'(chop), 0);
        check("R9 flag cleared", int'(duty), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 R1 restart turn-on", int'(chop), 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule